// File: doc/BRIEF.md
# Board Control Register File

This block is a bank of 32-bit control and status registers for a development board controller. It sits on a simple synchronous bus with an address, a write enable with write data, and a read enable with registered read data. Only the low part of the address is decoded, so the block appears at every alias of its window. It holds an eight-lamp LED register, an eight-character ASCII display buffer, a break register, an 8-bit general-purpose output register and a small set of registers that bit-bang an I2C line pair.

The display buffer is filled in one of two ways. A single word write turns a 32-bit value into eight uppercase hexadecimal characters. Separate byte-wide writes set one character position each. Every display write raises a one-cycle update strobe for the display driver. A write of one magic value to the soft-reset register raises a one-cycle reset request. A write to the I2C output register drives SCL and SDA and pulses a strobe so that an attached serial EEPROM model can take the new line levels. The EEPROM's SDA level comes back into bit 0 of the I2C input register.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the LED register and general-purpose outputs are 0, the break register is 0x0A, the I2C output enable is 0, the I2C output register is 0x3 (SCL=1, SDA=1), the I2C select bit is 1, every display byte is 0x20, and all three pulse outputs are low.
- R2: A read sampled with `bus_re` at a clock edge places its data on `bus_rdata` after that edge, and the data holds until the next read. Offsets 0x200 and 0x210 read 0. Offset 0x208 reads 0x10 when `BIG_ENDIAN` is 0 and 0x12 when it is 1. Any offset with no register reads 0.
- R3: Only the low `DEC_BITS` (20) address bits are decoded, so any value of the upper bits reaches the same register.
- R4: Offset 0x408 is the LED register. A write keeps only data bits 7:0, drives `led_out` and reads back zero-extended. `led_out` changes only on a write.
- R5: A write to 0x410 stores eight ASCII characters in the display. Position k (0..7, on `disp_chars[8k+7:8k]`) receives nibble k of the data counted from the most significant end. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46.
- R6: A write to 0x418 + 8k (k = 0..7) stores data bits 7:0 in display position k and leaves the other positions unchanged.
- R7: A write to 0x500 raises `soft_rst_req` for exactly the following cycle, but only when the data is exactly 0x00000042. Any other value raises nothing.
- R8: Offset 0x508 is an 8-bit break register and 0xA00 is an 8-bit general-purpose output register driving `gp_out`. Both keep data bits 7:0 and read back zero-extended. `gp_out` changes only on a write.
- R9: Offset 0xB18 is a 1-bit select register (data bit 0). A read at 0xA08 returns the full I2C output register while select is 1 and returns 0 while select is 0.
- R10: A read at 0xB00 returns the input value 0x3 with bit 0 replaced by the live `eeprom_sda_in`. Offset 0xB08 is a 2-bit output-enable register (data bits 1:0).
- R11: A write to 0xB10 stores all 32 data bits. Data bit 1 drives `i2c_scl` and bit 0 drives `i2c_sda` from the next cycle, and `i2c_wr_strobe` is high for that one cycle.
- R12: `disp_update` is high for exactly the cycle after each write to 0x410 or to one of the eight position offsets, and is low otherwise.
- R13: Writes to 0x200, 0x208, 0x210, to unmapped offsets and to a misaligned offset inside the display range change no state and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Bus byte address (low 20 bits decoded) |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| eeprom_sda_in | input | 1 | SDA level returned by the EEPROM |
| led_out | output | 8 | LED register bits |
| gp_out | output | 8 | General-purpose output register |
| disp_chars | output | 64 | Display characters, position k in bits 8k+7:8k |
| disp_update | output | 1 | One-cycle strobe after a display write |
| soft_rst_req | output | 1 | One-cycle soft-reset request |
| i2c_scl | output | 1 | SCL drive level |
| i2c_sda | output | 1 | SDA drive level |
| i2c_wr_strobe | output | 1 | One-cycle strobe after an I2C output write |

## Verification
Every result is due one cycle after the edge that samples the request. Read data, stored register values and the three pulses all appear after that single register stage. The driver applies stimulus on the falling edge. Read expectations go into a queue, and the monitor pops them on the falling edge that follows the sampling rising edge. Direct checks on the output pins and pulses take place on that same falling edge, and the pulses are checked again one cycle later to confirm they have dropped.

// File: rtl/board_ctrl_pkg.sv
package board_ctrl_pkg;

    // Register selector produced by the address decoder
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SWITCH,
        SEL_STATUS,
        SEL_JUMPER,
        SEL_LED,
        SEL_HEXWORD,
        SEL_CHAR,
        SEL_SOFTRST,
        SEL_BREAK,
        SEL_GPOUT,
        SEL_GPIN,
        SEL_I2C_IN,
        SEL_I2C_OE,
        SEL_I2C_OUT,
        SEL_I2C_SEL
    } reg_sel_e;

    localparam logic [31:0] OFF_SWITCH  = 32'h0000_0200;
    localparam logic [31:0] OFF_STATUS  = 32'h0000_0208;
    localparam logic [31:0] OFF_JUMPER  = 32'h0000_0210;
    localparam logic [31:0] OFF_LED     = 32'h0000_0408;
    localparam logic [31:0] OFF_HEXWORD = 32'h0000_0410;
    localparam logic [31:0] OFF_CHAR0   = 32'h0000_0418;
    localparam logic [31:0] OFF_SOFTRST = 32'h0000_0500;
    localparam logic [31:0] OFF_BREAK   = 32'h0000_0508;
    localparam logic [31:0] OFF_GPOUT   = 32'h0000_0A00;
    localparam logic [31:0] OFF_GPIN    = 32'h0000_0A08;
    localparam logic [31:0] OFF_I2C_IN  = 32'h0000_0B00;
    localparam logic [31:0] OFF_I2C_OE  = 32'h0000_0B08;
    localparam logic [31:0] OFF_I2C_OUT = 32'h0000_0B10;
    localparam logic [31:0] OFF_I2C_SEL = 32'h0000_0B18;

    localparam logic [31:0] SOFTRST_MAGIC = 32'h0000_0042;
    localparam logic [7:0]  ASCII_SPACE   = 8'h20;

    // One hex nibble to an uppercase ASCII character
    function automatic logic [7:0] nibble_to_ascii(input logic [3:0] nib);
        if (nib < 4'd10) begin
            nibble_to_ascii = 8'h30 + {4'h0, nib};
        end else begin
            nibble_to_ascii = 8'h37 + {4'h0, nib};
        end
    endfunction

endpackage

// File: rtl/board_ctrl_decode.sv
module board_ctrl_decode
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DEC_BITS = 20,
    parameter int N_CHARS  = 8,
    localparam int IDX_W   = (N_CHARS > 1) ? $clog2(N_CHARS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  char_idx
);

    localparam logic [31:0] CHAR_LAST = OFF_CHAR0 + 32'(8 * (N_CHARS - 1));

    logic [31:0] off;
    logic [31:0] char_rel;
    logic        unused_upper;

    assign off          = 32'(addr[DEC_BITS-1:0]);
    assign unused_upper = ^addr[ADDR_W-1:DEC_BITS];
    assign char_rel     = (off - OFF_CHAR0) >> 3;
    assign char_idx     = char_rel[IDX_W-1:0];

    always_comb begin
        sel = SEL_NONE;
        if (off >= OFF_CHAR0 && off <= CHAR_LAST && off[2:0] == 3'b000) begin
            sel = SEL_CHAR;
        end else begin
            case (off)
                OFF_SWITCH:  sel = SEL_SWITCH;
                OFF_STATUS:  sel = SEL_STATUS;
                OFF_JUMPER:  sel = SEL_JUMPER;
                OFF_LED:     sel = SEL_LED;
                OFF_HEXWORD: sel = SEL_HEXWORD;
                OFF_SOFTRST: sel = SEL_SOFTRST;
                OFF_BREAK:   sel = SEL_BREAK;
                OFF_GPOUT:   sel = SEL_GPOUT;
                OFF_GPIN:    sel = SEL_GPIN;
                OFF_I2C_IN:  sel = SEL_I2C_IN;
                OFF_I2C_OE:  sel = SEL_I2C_OE;
                OFF_I2C_OUT: sel = SEL_I2C_OUT;
                OFF_I2C_SEL: sel = SEL_I2C_SEL;
                default:     sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/board_ctrl_hexfmt.sv
module board_ctrl_hexfmt
    import board_ctrl_pkg::*;
#(
    parameter int N_CHARS = 8
) (
    input  logic [4*N_CHARS-1:0] word,
    output logic [8*N_CHARS-1:0] chars
);

    // Position 0 takes the most significant nibble
    for (genvar k = 0; k < N_CHARS; k++) begin : g_char
        assign chars[8*k +: 8] = nibble_to_ascii(word[4*(N_CHARS-1-k) +: 4]);
    end

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import board_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DEC_BITS   = 20,
    parameter bit BIG_ENDIAN = 1'b0,
    localparam int DATA_W    = 32,
    localparam int N_CHARS   = DATA_W / 4,
    localparam int DISP_W    = 8 * N_CHARS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eeprom_sda_in,
    output logic [7:0]        led_out,
    output logic [7:0]        gp_out,
    output logic [DISP_W-1:0] disp_chars,
    output logic              disp_update,
    output logic              soft_rst_req,
    output logic              i2c_scl,
    output logic              i2c_sda,
    output logic              i2c_wr_strobe
);

    localparam int          IDX_W       = $clog2(N_CHARS);
    localparam logic [31:0] STATUS_VAL  = BIG_ENDIAN ? 32'h12 : 32'h10;
    localparam logic [31:0] I2C_IN_RST  = 32'h3;
    localparam logic [7:0]  BREAK_RST   = 8'h0A;
    localparam logic [31:0] I2C_OUT_RST = 32'h3;

    typedef struct packed {
        logic [7:0]        led;
        logic [7:0]        brk;
        logic [7:0]        gpo;
        logic [1:0]        i2c_oe;
        logic [DATA_W-1:0] i2c_out;
        logic              i2c_sel;
        logic [DISP_W-1:0] disp;
        logic [DATA_W-1:0] rdata;
        logic              rst_pulse;
        logic              upd_pulse;
        logic              i2c_pulse;
    } state_t;

    state_t            st_d, st_q;
    reg_sel_e          sel;
    logic [IDX_W-1:0]  char_idx;
    logic [DISP_W-1:0] hex_chars;
    logic [DATA_W-1:0] rd_mux;

    board_ctrl_decode #(
        .ADDR_W  (ADDR_W),
        .DEC_BITS(DEC_BITS),
        .N_CHARS (N_CHARS)
    ) u_decode (
        .addr    (bus_addr),
        .sel     (sel),
        .char_idx(char_idx)
    );

    board_ctrl_hexfmt #(
        .N_CHARS(N_CHARS)
    ) u_hexfmt (
        .word (bus_wdata),
        .chars(hex_chars)
    );

    // Read multiplexer
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_STATUS:  rd_mux = STATUS_VAL;
            SEL_LED:     rd_mux = 32'(st_q.led);
            SEL_BREAK:   rd_mux = 32'(st_q.brk);
            SEL_GPOUT:   rd_mux = 32'(st_q.gpo);
            SEL_GPIN:    rd_mux = st_q.i2c_sel ? st_q.i2c_out : '0;
            SEL_I2C_IN:  rd_mux = {I2C_IN_RST[DATA_W-1:1], eeprom_sda_in};
            SEL_I2C_OE:  rd_mux = 32'(st_q.i2c_oe);
            SEL_I2C_OUT: rd_mux = st_q.i2c_out;
            SEL_I2C_SEL: rd_mux = 32'(st_q.i2c_sel);
            default:     rd_mux = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;
        st_d.upd_pulse = 1'b0;
        st_d.i2c_pulse = 1'b0;
        if (bus_we) begin
            case (sel)
                SEL_LED:     st_d.led = bus_wdata[7:0];
                SEL_HEXWORD: begin
                    st_d.disp      = hex_chars;
                    st_d.upd_pulse = 1'b1;
                end
                SEL_CHAR: begin
                    st_d.disp[{char_idx, 3'b000} +: 8] = bus_wdata[7:0];
                    st_d.upd_pulse = 1'b1;
                end
                SEL_SOFTRST: st_d.rst_pulse = (bus_wdata == SOFTRST_MAGIC);
                SEL_BREAK:   st_d.brk = bus_wdata[7:0];
                SEL_GPOUT:   st_d.gpo = bus_wdata[7:0];
                SEL_I2C_OE:  st_d.i2c_oe = bus_wdata[1:0];
                SEL_I2C_OUT: begin
                    st_d.i2c_out   = bus_wdata;
                    st_d.i2c_pulse = 1'b1;
                end
                SEL_I2C_SEL: st_d.i2c_sel = bus_wdata[0];
                default: ;
            endcase
        end
        if (bus_re) begin
            st_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.led       <= '0;
            st_q.brk       <= BREAK_RST;
            st_q.gpo       <= '0;
            st_q.i2c_oe    <= '0;
            st_q.i2c_out   <= I2C_OUT_RST;
            st_q.i2c_sel   <= 1'b1;
            st_q.disp      <= {N_CHARS{ASCII_SPACE}};
            st_q.rdata     <= '0;
            st_q.rst_pulse <= 1'b0;
            st_q.upd_pulse <= 1'b0;
            st_q.i2c_pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata     = st_q.rdata;
    assign led_out       = st_q.led;
    assign gp_out        = st_q.gpo;
    assign disp_chars    = st_q.disp;
    assign disp_update   = st_q.upd_pulse;
    assign soft_rst_req  = st_q.rst_pulse;
    assign i2c_scl       = st_q.i2c_out[1];
    assign i2c_sda       = st_q.i2c_out[0];
    assign i2c_wr_strobe = st_q.i2c_pulse;

endmodule

// File: rtl/board_ctrl_regs_chk.sv
module board_ctrl_regs_chk #(
    parameter int DEC_BITS = 20
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DEC_BITS-1:0] bus_off,
    input logic                bus_we,
    input logic [31:0]         bus_wdata,
    input logic [7:0]          led_out,
    input logic [7:0]          gp_out,
    input logic                soft_rst_req,
    input logic                disp_update,
    input logic                i2c_scl,
    input logic                i2c_sda,
    input logic                i2c_wr_strobe
);

    localparam logic [DEC_BITS-1:0] SR_OFF   = DEC_BITS'(32'h500);
    localparam logic [DEC_BITS-1:0] DISP_LO  = DEC_BITS'(32'h410);
    localparam logic [DEC_BITS-1:0] DISP_HI  = DEC_BITS'(32'h450);

    // R7
    soft_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_req |-> ($past(bus_we) && $past(bus_off) == SR_OFF
                          && $past(bus_wdata) == 32'h42));

    // R12
    disp_update_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_update |-> ($past(bus_we) && $past(bus_off) >= DISP_LO
                         && $past(bus_off) <= DISP_HI));

    // R11
    i2c_strobe_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_wr_strobe |-> ($past(bus_we) && i2c_scl == $past(bus_wdata[1])
                           && i2c_sda == $past(bus_wdata[0])));

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(led_out));

    // R8
    gp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_we) |-> $stable(gp_out));

endmodule

bind board_ctrl_regs board_ctrl_regs_chk #(
    .DEC_BITS(DEC_BITS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_off      (bus_addr[DEC_BITS-1:0]),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .led_out      (led_out),
    .gp_out       (gp_out),
    .soft_rst_req (soft_rst_req),
    .disp_update  (disp_update),
    .i2c_scl      (i2c_scl),
    .i2c_sda      (i2c_sda),
    .i2c_wr_strobe(i2c_wr_strobe)
);

// File: tb/board_ctrl_regs_test.sv
module board_ctrl_regs_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic        eeprom_sda_in = 1'b1;
    logic [7:0]  led_out;
    logic [7:0]  gp_out;
    logic [63:0] disp_chars;
    logic        disp_update;
    logic        soft_rst_req;
    logic        i2c_scl;
    logic        i2c_sda;
    logic        i2c_wr_strobe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] exp;
    } exp_t;

    exp_t sb_q[$];
    logic rd_v = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    board_ctrl_regs uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_re       (bus_re),
        .bus_rdata    (bus_rdata),
        .eeprom_sda_in(eeprom_sda_in),
        .led_out      (led_out),
        .gp_out       (gp_out),
        .disp_chars   (disp_chars),
        .disp_update  (disp_update),
        .soft_rst_req (soft_rst_req),
        .i2c_scl      (i2c_scl),
        .i2c_sda      (i2c_sda),
        .i2c_wr_strobe(i2c_wr_strobe)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] hex_char(input logic [3:0] n);
        return (n < 10) ? (8'h30 + 8'(n)) : (8'h41 + 8'(n) - 8'd10);
    endfunction

    function automatic logic [63:0] hex_line(input logic [31:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = hex_char(v[31 - 4*k -: 4]);
        return r;
    endfunction

    // Monitor: compare read data one cycle after the sampling edge
    always @(posedge clk) rd_v <= bus_re && rst_n;

    always @(negedge clk) begin
        if (rd_v) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fails++;
                $display("FAIL scoreboard: actual %h expected none", bus_rdata);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, 64'(bus_rdata), 64'(e.exp));
            end
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string tag);
        exp_t e;
        @(negedge clk);
        e.tag = tag;
        e.exp = exp;
        sb_q.push_back(e);
        bus_addr = a;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    initial begin
        logic [63:0] disp_exp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 led", 64'(led_out), 64'h0);
        check("R1 gp", 64'(gp_out), 64'h0);
        check("R1 scl/sda", 64'({i2c_scl, i2c_sda}), 64'h3);
        check("R1 display", disp_chars, {8{8'h20}});
        check("R1 pulses", 64'({disp_update, soft_rst_req, i2c_wr_strobe}), 64'h0);
        rd(32'h508, 32'h0A, "R1 break reset");
        rd(32'hB08, 32'h0,  "R1 oe reset");
        rd(32'hB10, 32'h3,  "R1 i2c out reset");
        rd(32'hB18, 32'h1,  "R1 select reset");
        rd(32'hA08, 32'h3,  "R1 R9 loopback at reset");

        // R2 fixed and unmapped reads
        rd(32'h200, 32'h0,  "R2 switches");
        rd(32'h208, 32'h10, "R2 status");
        rd(32'h210, 32'h0,  "R2 jumpers");
        rd(32'h404, 32'h0,  "R2 unmapped 0x404");
        rd(32'h9FC, 32'h0,  "R2 unmapped 0x9FC");

        // R4 LED register
        wr(32'h408, 32'hDEADBEA5);
        check("R4 led_out", 64'(led_out), 64'hA5);
        rd(32'h408, 32'hA5, "R4 led read");

        // R3 upper address bits ignored
        wr(32'h1F00_0408, 32'h3C);
        check("R3 led via alias", 64'(led_out), 64'h3C);
        rd(32'hFFF0_0408, 32'h3C, "R3 alias read");

        // R5 / R12 hex word writes
        wr(32'h410, 32'h1234ABCF);
        check("R5 hex pattern 1", disp_chars, hex_line(32'h1234ABCF));
        check("R12 update pulse", 64'(disp_update), 64'h1);
        @(negedge clk);
        check("R12 update drops", 64'(disp_update), 64'h0);
        wr(32'h410, 32'h09F0A5E7);
        disp_exp = hex_line(32'h09F0A5E7);
        check("R5 hex pattern 2", disp_chars, disp_exp);
        check("R5 position 0 is top nibble", 64'(disp_chars[7:0]), 64'h30);

        // R6 per-position writes
        for (int k = 0; k < 8; k++) begin
            wr(32'h418 + 32'(8 * k), 32'hFFFF_FF00 | 32'(8'h61 + k));
            disp_exp[8*k +: 8] = 8'h61 + 8'(k);
            check($sformatf("R6 position %0d", k), disp_chars, disp_exp);
            check("R12 pulse on char write", 64'(disp_update), 64'h1);
        end

        // R13 misaligned display offset
        wr(32'h41C, 32'h5A);
        check("R13 misaligned no change", disp_chars, disp_exp);
        check("R13 misaligned no pulse", 64'(disp_update), 64'h0);

        // R7 soft reset
        wr(32'h500, 32'h42);
        check("R7 request pulse", 64'(soft_rst_req), 64'h1);
        @(negedge clk);
        check("R7 request drops", 64'(soft_rst_req), 64'h0);
        wr(32'h500, 32'h43);
        check("R7 wrong value", 64'(soft_rst_req), 64'h0);
        wr(32'h500, 32'h142);
        check("R7 upper bits set", 64'(soft_rst_req), 64'h0);

        // R8 break and general-purpose output
        wr(32'h508, 32'h1FF);
        rd(32'h508, 32'hFF, "R8 break read");
        wr(32'hA00, 32'h3C5);
        check("R8 gp_out", 64'(gp_out), 64'hC5);
        rd(32'hA00, 32'hC5, "R8 gp read");

        // R11 I2C output
        wr(32'hB10, 32'h2);
        check("R11 lines scl1 sda0", 64'({i2c_scl, i2c_sda}), 64'h2);
        check("R11 strobe", 64'(i2c_wr_strobe), 64'h1);
        @(negedge clk);
        check("R11 strobe drops", 64'(i2c_wr_strobe), 64'h0);
        rd(32'hB10, 32'h2, "R11 read");
        rd(32'hA08, 32'h2, "R9 loopback select 1");
        wr(32'hB10, 32'hFFFFFF01);
        check("R11 lines scl0 sda1", 64'({i2c_scl, i2c_sda}), 64'h1);
        rd(32'hB10, 32'hFFFFFF01, "R11 full word kept");

        // R9 select
        wr(32'hB18, 32'h2);
        rd(32'hB18, 32'h0, "R9 select bit 0 only");
        rd(32'hA08, 32'h0, "R9 loopback select 0");
        wr(32'hB18, 32'h1);
        rd(32'hA08, 32'hFFFFFF01, "R9 loopback restored");

        // R10 input and output enable
        eeprom_sda_in = 1'b0;
        rd(32'hB00, 32'h2, "R10 sda low");
        eeprom_sda_in = 1'b1;
        rd(32'hB00, 32'h3, "R10 sda high");
        wr(32'hB08, 32'hFF);
        rd(32'hB08, 32'h3, "R10 oe two bits");

        // R13 writes to read-only and unmapped offsets
        wr(32'h200, 32'h55);
        wr(32'h210, 32'h55);
        wr(32'h208, 32'h55);
        wr(32'h404, 32'h55);
        check("R13 led unchanged", 64'(led_out), 64'h3C);
        check("R13 gp unchanged", 64'(gp_out), 64'hC5);
        check("R13 no pulses", 64'({disp_update, soft_rst_req, i2c_wr_strobe}), 64'h0);
        rd(32'h200, 32'h0,  "R13 switches still 0");
        rd(32'h208, 32'h10, "R13 status unchanged");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule